// File: doc/BRIEF.md
# Core Idle-State Power Sequencer

This block steps each core of a multi-core cluster (four by default) into and out of idle states and decides when the shared uncore may sleep as well. A core asks to go idle with a one-cycle request and a 2-bit target depth. The sequencer then drives that core's execution enable, pipeline clock enable, core clock enable, state-save and state-restore handshakes, and power-gate enable in a fixed order. A wake pulse brings the core back along the reverse path. Every core has its own sequencer and its own power gate. One core can therefore lose its supply while the others keep running.

The shallow targets only stop clocks. The deepest target first saves the core state and stops all clocks, then opens the core's power gate. After the gate opens, a settle counter with a programmable length must expire before the core counts as idle. The same counter paces the return of the supply on exit. When every core sits gated, a package-level controller stops the uncore clock and puts I/O into low power. Any wake request first brings the package back up, and only then does the core's own exit begin. A wake that arrives partway through entry cancels it, and the core leaves through the exit steps that match how far entry got.

Top module: `cstate_sequencer`

## Requirements
- R1: After reset every core runs with its execution, pipeline clock and core clock enables high and power gate low, the uncore clock enable is high, I/O low power is low, and both handshake requests are low.
- R2: The target code is 2 bits. Code 0 (C1) and code 1 (C2) drop execution and the pipeline clock but keep the core clock on and the power gate low. A wake returns the core to running.
- R3: Target code 2 (C3) drops execution and both clock enables and keeps the power gate low. A wake re-enables the clocks and returns to running without a restore handshake.
- R4: Target code 3 (C6) enters in this order: execution drops; the save request is raised and held until save-done is seen; both clocks stop; only then does the power gate rise.
- R5: Each time the power gate is released, both clock enables stay low for exactly cfg_settle+1 cycles before the clocks come back.
- R6: Exit from C6 runs in this order: the gate is released, the clocks are re-enabled, the restore request is held until restore-done, and then execution resumes.
- R7: A core that is idling or sequencing does not change the outputs of any other core.
- R8: The uncore clock stops and I/O low power rises only while every core is gated idle. While any core is not gated idle, the uncore clock stays on.
- R9: A wake to a core while the package is asleep restores the uncore clock and normal I/O before that core's power gate is released.
- R10: A wake that arrives before the power gate rises aborts entry. The core returns to running with the gate never raised and no restore handshake.
- R11: A wake during the power-gate settle window releases the gate, restarts the clocks, performs a restore handshake, and resumes execution.
- R12: When an idle request and a wake arrive for a running core in the same cycle, the wake wins and the core keeps running.
- R13: The wake-to-running latency from C6 is longer than from C1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_settle | input | SETTLE_W | Settle length in cycles for power gate and package wake |
| idle_req | input | NCORES | One-cycle idle request per core |
| idle_tgt | input | 2*NCORES | Target code per core, core c at bits [2c+1:2c] |
| wake | input | NCORES | Interrupt or wake pulse per core |
| save_done | input | NCORES | State save completed, per core |
| restore_done | input | NCORES | State restore completed, per core |
| core_run | output | NCORES | Execution enable per core |
| pipe_clk_en | output | NCORES | Pipeline clock enable per core |
| core_clk_en | output | NCORES | Whole-core clock enable per core |
| save_req | output | NCORES | State save request per core |
| restore_req | output | NCORES | State restore request per core |
| pwr_gate | output | NCORES | Power gate open, core supply removed |
| uncore_clk_en | output | 1 | Uncore clock distribution enable |
| io_lowpwr | output | 1 | I/O low-power mode |

## Verification
On every cycle the assertions check the step ordering: the gate rises only after the core clock was already off, the save request is held while its handshake is pending, the restore request and execution restart only from clocked states, the package sleeps only while all gates are open, and no gate is released while the uncore is down. Other behaviour only the bench scenarios can show. That covers the exact settle length, the idle outputs each target code leaves behind, that neighbouring cores are not disturbed, the two abort paths, and the relative exit latencies of the depths.

// File: rtl/cstate_seq_pkg.sv
package cstate_seq_pkg;

    typedef enum logic [1:0] {
        TGT_C1 = 2'd0,
        TGT_C2 = 2'd1,
        TGT_C3 = 2'd2,
        TGT_C6 = 2'd3
    } idle_tgt_e;

    typedef enum logic [3:0] {
        CS_RUN,
        CS_HALT,
        CS_SAVE,
        CS_CLKOFF,
        CS_GATE,
        CS_IDLE_PIPE,
        CS_IDLE_CLK,
        CS_IDLE_GATED,
        CS_WAIT_PKG,
        CS_UNGATE,
        CS_CLKON,
        CS_RESTORE
    } core_st_e;

    typedef enum logic [1:0] {
        PK_ON,
        PK_OFF,
        PK_WAKE
    } pkg_st_e;

    typedef struct packed {
        logic run;
        logic pipe_clk;
        logic core_clk;
        logic save_req;
        logic restore_req;
        logic gate;
    } core_drv_t;

    // Output decode for one core sequencer state.
    function automatic core_drv_t drive_of(core_st_e s);
        core_drv_t d;
        d = '0;
        case (s)
            CS_RUN:        begin d.run = 1'b1; d.pipe_clk = 1'b1; d.core_clk = 1'b1; end
            CS_HALT:       begin d.pipe_clk = 1'b1; d.core_clk = 1'b1; end
            CS_SAVE:       begin d.pipe_clk = 1'b1; d.core_clk = 1'b1; d.save_req = 1'b1; end
            CS_IDLE_PIPE:  d.core_clk = 1'b1;
            CS_GATE,
            CS_IDLE_GATED,
            CS_WAIT_PKG:   d.gate = 1'b1;
            CS_CLKON:      begin d.pipe_clk = 1'b1; d.core_clk = 1'b1; end
            CS_RESTORE:    begin d.pipe_clk = 1'b1; d.core_clk = 1'b1; d.restore_req = 1'b1; end
            default:       d = '0;
        endcase
        return d;
    endfunction

    function automatic core_st_e shallow_dest(idle_tgt_e t);
        core_st_e s;
        case (t)
            TGT_C1, TGT_C2: s = CS_IDLE_PIPE;
            TGT_C3:         s = CS_IDLE_CLK;
            default:        s = CS_SAVE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cst_settle_timer.sv
module cst_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/cst_core_seq.sv
module cst_core_seq
    import cstate_seq_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                idle_req,
    input  logic [1:0]          idle_tgt,
    input  logic                wake,
    input  logic                save_done,
    input  logic                restore_done,
    input  logic                pkg_ready,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output core_drv_t           drv,
    output logic                gated_idle,
    output logic                wake_pend
);
    core_st_e  st, st_nx;
    idle_tgt_e tgt_q;
    logic      lost_q, lost_nx;
    logic      tmr_load, tmr_done;

    cst_settle_timer #(.W(SETTLE_W)) i_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (cfg_settle),
        .done     (tmr_done)
    );

    always_comb begin
        st_nx    = st;
        lost_nx  = lost_q;
        tmr_load = 1'b0;
        case (st)
            CS_RUN:        if (!wake && idle_req) st_nx = CS_HALT;
            CS_HALT:       st_nx = wake ? CS_RUN : shallow_dest(tgt_q);
            CS_SAVE: begin
                if (wake)           st_nx = CS_RUN;
                else if (save_done) st_nx = CS_CLKOFF;
            end
            CS_CLKOFF: begin
                if (wake) st_nx = CS_CLKON;
                else begin
                    st_nx    = CS_GATE;
                    tmr_load = 1'b1;
                    lost_nx  = 1'b1;
                end
            end
            CS_GATE: begin
                if (wake) begin
                    st_nx    = CS_UNGATE;
                    tmr_load = 1'b1;
                end else if (tmr_done) st_nx = CS_IDLE_GATED;
            end
            CS_IDLE_PIPE:  if (wake) st_nx = CS_RUN;
            CS_IDLE_CLK:   if (wake) st_nx = CS_CLKON;
            CS_IDLE_GATED: if (wake) st_nx = CS_WAIT_PKG;
            CS_WAIT_PKG: begin
                if (pkg_ready) begin
                    st_nx    = CS_UNGATE;
                    tmr_load = 1'b1;
                end
            end
            CS_UNGATE:     if (tmr_done) st_nx = CS_CLKON;
            CS_CLKON:      st_nx = lost_q ? CS_RESTORE : CS_RUN;
            CS_RESTORE: begin
                if (restore_done) begin
                    st_nx   = CS_RUN;
                    lost_nx = 1'b0;
                end
            end
            default:       st_nx = CS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CS_RUN;
            tgt_q  <= TGT_C1;
            lost_q <= 1'b0;
        end else begin
            st     <= st_nx;
            lost_q <= lost_nx;
            if (st == CS_RUN && idle_req && !wake)
                tgt_q <= idle_tgt_e'(idle_tgt);
        end
    end

    assign drv        = drive_of(st);
    assign gated_idle = (st == CS_IDLE_GATED);
    assign wake_pend  = (st == CS_WAIT_PKG);

    // R4: the gate never rises while the core clock was on in the cycle before
    a_r4_clk_off_before_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.gate) |-> !$past(drv.core_clk));

    // R4: a pending save with no wake keeps its request up
    a_r4_save_held: assert property (@(posedge clk) disable iff (rst)
        (drv.save_req && !save_done && !wake) |=> drv.save_req);

    // R6: restore only begins from a clocked, ungated step
    a_r6_restore_after_clkon: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.restore_req) |-> (!drv.gate && $past(drv.core_clk)));

    // R6: execution restarts only out of a state where the core clock ran
    a_r6_run_from_clocked: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.run) |-> $past(drv.core_clk));

    // R12: a wake seen while running keeps the core running
    a_r12_wake_priority: assert property (@(posedge clk) disable iff (rst)
        (drv.run && wake) |=> drv.run);
endmodule

// File: rtl/cst_pkg_ctrl.sv
module cst_pkg_ctrl
    import cstate_seq_pkg::*;
#(
    parameter int NCORES   = 4,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCORES-1:0]   gated_idle,
    input  logic [NCORES-1:0]   wake,
    input  logic [NCORES-1:0]   wake_pend,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output logic                uncore_clk_en,
    output logic                io_lowpwr,
    output logic                pkg_ready
);
    pkg_st_e st, st_nx;
    logic    tmr_load, tmr_done;

    cst_settle_timer #(.W(SETTLE_W)) i_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (cfg_settle),
        .done     (tmr_done)
    );

    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        case (st)
            PK_ON:   if ((&gated_idle) && !(|wake)) st_nx = PK_OFF;
            PK_OFF: begin
                if (|wake_pend) begin
                    st_nx    = PK_WAKE;
                    tmr_load = 1'b1;
                end
            end
            PK_WAKE: if (tmr_done) st_nx = PK_ON;
            default: st_nx = PK_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= PK_ON;
        else     st <= st_nx;
    end

    assign uncore_clk_en = (st != PK_OFF);
    assign io_lowpwr     = (st == PK_OFF);
    assign pkg_ready     = (st == PK_ON);

    // R8: the package only sleeps out of a cycle in which every core was gated idle
    a_r8_sleep_needs_all_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(io_lowpwr) |-> $past(&gated_idle));
endmodule

// File: rtl/cstate_sequencer.sv
module cstate_sequencer
    import cstate_seq_pkg::*;
#(
    parameter int NCORES   = 4,
    parameter int SETTLE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SETTLE_W-1:0]   cfg_settle,
    input  logic [NCORES-1:0]     idle_req,
    input  logic [2*NCORES-1:0]   idle_tgt,
    input  logic [NCORES-1:0]     wake,
    input  logic [NCORES-1:0]     save_done,
    input  logic [NCORES-1:0]     restore_done,
    output logic [NCORES-1:0]     core_run,
    output logic [NCORES-1:0]     pipe_clk_en,
    output logic [NCORES-1:0]     core_clk_en,
    output logic [NCORES-1:0]     save_req,
    output logic [NCORES-1:0]     restore_req,
    output logic [NCORES-1:0]     pwr_gate,
    output logic                  uncore_clk_en,
    output logic                  io_lowpwr
);
    localparam int TGT_W = 2;

    logic [NCORES-1:0] gated_idle, wake_pend;
    logic              pkg_ready;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        core_drv_t drv;

        cst_core_seq #(.SETTLE_W(SETTLE_W)) i_seq (
            .clk          (clk),
            .rst          (rst),
            .idle_req     (idle_req[c]),
            .idle_tgt     (idle_tgt[c*TGT_W +: TGT_W]),
            .wake         (wake[c]),
            .save_done    (save_done[c]),
            .restore_done (restore_done[c]),
            .pkg_ready    (pkg_ready),
            .cfg_settle   (cfg_settle),
            .drv          (drv),
            .gated_idle   (gated_idle[c]),
            .wake_pend    (wake_pend[c])
        );

        assign core_run[c]    = drv.run;
        assign pipe_clk_en[c] = drv.pipe_clk;
        assign core_clk_en[c] = drv.core_clk;
        assign save_req[c]    = drv.save_req;
        assign restore_req[c] = drv.restore_req;
        assign pwr_gate[c]    = drv.gate;

        // R9: a core supply is only restored while the uncore is awake
        a_r9_ungate_needs_uncore: assert property (@(posedge clk) disable iff (rst)
            $fell(pwr_gate[c]) |-> (uncore_clk_en && !io_lowpwr));
    end

    cst_pkg_ctrl #(.NCORES(NCORES), .SETTLE_W(SETTLE_W)) i_pkg (
        .clk           (clk),
        .rst           (rst),
        .gated_idle    (gated_idle),
        .wake          (wake),
        .wake_pend     (wake_pend),
        .cfg_settle    (cfg_settle),
        .uncore_clk_en (uncore_clk_en),
        .io_lowpwr     (io_lowpwr),
        .pkg_ready     (pkg_ready)
    );

    // R8: package low power implies every core gate is open
    a_r8_lowpwr_all_gated: assert property (@(posedge clk) disable iff (rst)
        io_lowpwr |-> (&pwr_gate));
endmodule

// File: tb/test_cstate_sequencer.sv
`timescale 1ns/1ps
module test_cstate_sequencer;
    localparam int NC = 4;
    localparam int SW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [SW-1:0]   cfg_settle = 8'd3;
    logic [NC-1:0]   idle_req = '0;
    logic [2*NC-1:0] idle_tgt = '0;
    logic [NC-1:0]   wake = '0;
    logic [NC-1:0]   save_done = '0;
    logic [NC-1:0]   restore_done = '0;
    logic [NC-1:0]   core_run, pipe_clk_en, core_clk_en, save_req, restore_req, pwr_gate;
    logic            uncore_clk_en, io_lowpwr;
    logic            hold_save = 1'b0;
    logic            clr_mon = 1'b0;
    bit              finished = 1'b0;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    int t_save[NC], t_clkoff[NC], t_gate[NC], t_ungate[NC], t_clkon[NC], t_restore[NC], n_ungate[NC];
    int t_unc_on;

    always #2 clk = ~clk;

    cstate_sequencer #(.NCORES(NC), .SETTLE_W(SW)) i_cstate_sequencer (
        .clk(clk), .rst(rst), .cfg_settle(cfg_settle), .idle_req(idle_req),
        .idle_tgt(idle_tgt), .wake(wake), .save_done(save_done),
        .restore_done(restore_done), .core_run(core_run), .pipe_clk_en(pipe_clk_en),
        .core_clk_en(core_clk_en), .save_req(save_req), .restore_req(restore_req),
        .pwr_gate(pwr_gate), .uncore_clk_en(uncore_clk_en), .io_lowpwr(io_lowpwr)
    );

    // Handshake responders, driven away from the active edge
    always @(negedge clk) begin
        save_done    <= hold_save ? '0 : save_req;
        restore_done <= restore_req;
    end

    // Event monitor: samples pre-update values at each edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (clr_mon) begin
            for (int c = 0; c < NC; c++) begin
                t_save[c] = -1; t_clkoff[c] = -1; t_gate[c] = -1;
                t_ungate[c] = -1; t_clkon[c] = -1; t_restore[c] = -1; n_ungate[c] = 0;
            end
            t_unc_on = -1;
        end else begin
            for (int c = 0; c < NC; c++) begin
                if (save_req[c] && t_save[c] < 0) t_save[c] = cyc;
                if (!core_clk_en[c] && t_clkoff[c] < 0) t_clkoff[c] = cyc;
                if (pwr_gate[c] && t_gate[c] < 0) t_gate[c] = cyc;
                if (t_gate[c] >= 0 && !pwr_gate[c] && t_ungate[c] < 0) t_ungate[c] = cyc;
                if (t_ungate[c] >= 0 && !pwr_gate[c] && !core_clk_en[c] && t_clkon[c] < 0)
                    n_ungate[c] = n_ungate[c] + 1;
                if (t_clkoff[c] >= 0 && core_clk_en[c] && t_clkon[c] < 0) t_clkon[c] = cyc;
                if (restore_req[c] && t_restore[c] < 0) t_restore[c] = cyc;
            end
            if (uncore_clk_en && t_unc_on < 0) t_unc_on = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        @(negedge clk) clr_mon = 1'b1;
        @(negedge clk) clr_mon = 1'b0;
    endtask

    task automatic go_idle(input int c, input logic [1:0] t);
        @(negedge clk);
        idle_req[c] = 1'b1;
        idle_tgt[c*2 +: 2] = t;
        @(negedge clk);
        idle_req[c] = 1'b0;
    endtask

    task automatic pulse_wake(input int c);
        @(negedge clk) wake[c] = 1'b1;
        @(negedge clk) wake[c] = 1'b0;
    endtask

    // Wake and count edges until the core runs again
    task automatic wake_latency(input int c, output int lat);
        lat = 0;
        @(negedge clk) wake[c] = 1'b1;
        @(negedge clk) begin wake[c] = 1'b0; lat = 1; end
        while (!core_run[c] && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // {core[8:7], tgt[6:5], pipe[4], coreclk[3], gate[2], restore[1], save[0]}
    localparam logic [8:0] VEC [0:5] = '{
        9'b00_00_01000,
        9'b01_01_01000,
        9'b10_10_00000,
        9'b11_11_00111,
        9'b01_11_00111,
        9'b00_10_00000
    };

    initial begin
        int lat1, lat6;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        clear_mon();

        // R1: reset state
        chk(core_run == '1, "R1 run", core_run, 15);
        chk(pipe_clk_en == '1 && core_clk_en == '1, "R1 clocks", {pipe_clk_en, core_clk_en}, 255);
        chk(pwr_gate == '0 && save_req == '0 && restore_req == '0, "R1 gate/handshake",
            {pwr_gate, save_req, restore_req}, 0);
        chk(uncore_clk_en && !io_lowpwr, "R1 uncore", {uncore_clk_en, io_lowpwr}, 2);

        // Table walk: one core per entry, entry then exit
        cfg_settle = 8'd3;
        foreach (VEC[i]) begin
            int c;
            logic [1:0] t;
            string rq;
            c  = int'(VEC[i][8:7]);
            t  = VEC[i][6:5];
            rq = (t < 2) ? "R2" : (t == 2) ? "R3" : "R4";
            clear_mon();
            go_idle(c, t);
            wait_cyc(20);
            chk(!core_run[c], rq, core_run[c], 0);
            chk(pipe_clk_en[c] == VEC[i][4], rq, pipe_clk_en[c], VEC[i][4]);
            chk(core_clk_en[c] == VEC[i][3], rq, core_clk_en[c], VEC[i][3]);
            chk(pwr_gate[c] == VEC[i][2], rq, pwr_gate[c], VEC[i][2]);
            chk((t_save[c] >= 0) == VEC[i][0], rq, t_save[c] >= 0, VEC[i][0]);
            for (int o = 0; o < NC; o++)
                if (o != c) chk(core_run[o] && core_clk_en[o] && !pwr_gate[o], "R7 neighbour",
                                core_run[o], 1);
            chk(uncore_clk_en && !io_lowpwr, "R8 partial idle", uncore_clk_en, 1);
            if (t == 2'd3)
                chk(t_save[c] < t_clkoff[c] && t_clkoff[c] < t_gate[c], "R4 order",
                    t_gate[c] - t_clkoff[c], 1);
            pulse_wake(c);
            wait_cyc(20);
            chk(core_run[c] && pipe_clk_en[c] && core_clk_en[c] && !pwr_gate[c],
                (t == 2'd3) ? "R6" : rq, core_run[c], 1);
            chk((t_restore[c] >= 0) == VEC[i][1], (t == 2'd3) ? "R6" : "R3",
                t_restore[c] >= 0, VEC[i][1]);
            if (t == 2'd3) begin
                chk(t_ungate[c] < t_clkon[c] && t_clkon[c] < t_restore[c], "R6 order",
                    t_restore[c] - t_clkon[c], 1);
                chk(n_ungate[c] == int'(cfg_settle) + 1, "R5 settle", n_ungate[c],
                    int'(cfg_settle) + 1);
            end
        end

        // R5 with zero settle
        cfg_settle = 8'd0;
        clear_mon();
        go_idle(2, 2'd3);
        wait_cyc(15);
        pulse_wake(2);
        wait_cyc(15);
        chk(n_ungate[2] == 1, "R5 zero settle", n_ungate[2], 1);
        chk(core_run[2], "R6 zero settle", core_run[2], 1);

        // R8/R9: package idle and package-first wake
        cfg_settle = 8'd2;
        for (int c = 0; c < NC - 1; c++) go_idle(c, 2'd3);
        wait_cyc(20);
        chk(uncore_clk_en && !io_lowpwr, "R8 three gated", {uncore_clk_en, io_lowpwr}, 2);
        go_idle(NC - 1, 2'd3);
        wait_cyc(20);
        chk(!uncore_clk_en && io_lowpwr, "R8 all gated", {uncore_clk_en, io_lowpwr}, 1);
        clear_mon();
        pulse_wake(2);
        wait_cyc(25);
        chk(core_run[2], "R9 core back", core_run[2], 1);
        chk(t_unc_on >= 0 && t_unc_on < t_ungate[2], "R9 uncore first", t_unc_on, t_ungate[2] - 1);
        chk(pwr_gate[0] && pwr_gate[1] && pwr_gate[3], "R7 others stay gated", pwr_gate, 11);
        chk(uncore_clk_en && !io_lowpwr, "R8 awake with one core", uncore_clk_en, 1);
        pulse_wake(0);
        pulse_wake(1);
        pulse_wake(3);
        wait_cyc(25);
        chk(core_run == '1, "R6 all back", core_run, 15);

        // R10: abort while the save handshake is pending
        hold_save = 1'b1;
        clear_mon();
        go_idle(1, 2'd3);
        wait_cyc(5);
        chk(save_req[1] && core_clk_en[1], "R4 save wait", {save_req[1], core_clk_en[1]}, 3);
        pulse_wake(1);
        wait_cyc(3);
        hold_save = 1'b0;
        chk(core_run[1], "R10 run", core_run[1], 1);
        chk(t_gate[1] < 0, "R10 no gate", t_gate[1], -1);
        chk(t_restore[1] < 0, "R10 no restore", t_restore[1], -1);

        // R11: abort during the gate settle window
        cfg_settle = 8'd20;
        clear_mon();
        go_idle(0, 2'd3);
        for (int k = 0; k < 50 && !pwr_gate[0]; k++) @(negedge clk);
        wake[0] = 1'b1;
        @(negedge clk) wake[0] = 1'b0;
        wait_cyc(40);
        chk(core_run[0] && !pwr_gate[0], "R11 run", core_run[0], 1);
        chk(t_restore[0] > t_ungate[0] && t_ungate[0] > 0, "R11 restore", t_restore[0], t_ungate[0] + 2);
        chk(n_ungate[0] == 21, "R11 settle", n_ungate[0], 21);

        // R12: simultaneous idle request and wake
        cfg_settle = 8'd2;
        clear_mon();
        @(negedge clk);
        idle_req[3] = 1'b1; idle_tgt[7:6] = 2'd3; wake[3] = 1'b1;
        @(negedge clk);
        idle_req[3] = 1'b0; wake[3] = 1'b0;
        begin
            int drops;
            drops = 0;
            repeat (6) begin
                @(negedge clk);
                if (!core_run[3]) drops++;
            end
            chk(drops == 0, "R12 stays running", drops, 0);
        end
        chk(t_save[3] < 0, "R12 no save", t_save[3], -1);

        // R13: deeper exit is slower
        go_idle(3, 2'd0);
        wait_cyc(5);
        wake_latency(3, lat1);
        go_idle(3, 2'd3);
        wait_cyc(15);
        wake_latency(3, lat6);
        chk(lat6 > lat1, "R13 latency", lat6, lat1 + 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule